// File: doc/BRIEF.md
# Multi-Channel Compare Timer

This block holds six independent up-counting timer channels behind a small synchronous register bus. Each channel has a control word, a clock-select word, a counter and a compare value. Each channel picks one of two tick-enable inputs, which stand for a fast and a slow clock source, and can halve that tick rate. A channel runs in one of three modes. In one-shot mode it stops at the compare value. In repeat mode it reloads to zero on each match. In free-run mode it ignores the compare value and wraps.

A compare match sets a sticky pending flag for that channel. A shared enable register selects which pending flags drive the single combined interrupt output. Software clears a flag by writing 1 to its bit in the shared acknowledge word. Each channel is controlled by a two-state machine. In `CH_HALT` the counter holds. `CH_HALT` goes to `CH_COUNT` on a control write with the enable bit set ("start"). `CH_COUNT` returns to `CH_HALT` on a control write with the enable bit clear ("stop"), or on a one-shot compare match ("expire").

Top module: `ctm_top`

## Requirements
- R1: After reset every enable, pending, control, clock, counter and compare field reads 0 and `irq` is low.
- R2: Word addresses: interrupt enable at 0x00 (bit n-1 = channel n), pending/acknowledge at 0x08. For channel n (1..6): control at 0x10·n, clock at 0x10·n+0x4, counter at 0x10·n+0x8, compare at 0x10·n+0xC. The counter is read-only: writes to it are ignored. Other addresses read 0.
- R3: Control bit 0 starts (1) or stops (0) the channel and reads back as the running state. Bits [5:4] select the mode: 0 one-shot, 1 repeat, 2 or 3 free-run. Writing bit 1 as 1 makes the counter read 0 on the next cycle, and bit 1 always reads 0.
- R4: Clock bit 4 selects `tick_slow` (1) or `tick_fast` (0). Clock bit 0 set makes the counter advance on every second selected tick instead of every tick. A halted channel's counter does not change.
- R5: In repeat mode, when an advance would make the counter equal the compare value, the channel's pending bit is set, the counter becomes 0 and counting continues.
- R6: In one-shot mode, when the counter advances to the compare value, the pending bit is set, the counter stays there and control bit 0 reads 0.
- R7: In free-run mode the counter wraps from all-ones to 0 and the pending bit is never set.
- R8: Reading 0x08 returns the pending bits. Writing 1 to bit n-1 of 0x08 clears channel n's pending bit, so 0x3F clears all six. Bits written as 0 are unchanged.
- R9: `irq` is high exactly when some channel has both its pending bit and its enable bit set. Pending bits are set regardless of the enable bits.
- R10: A control write to a channel takes precedence over counting: the counter does not advance in the write cycle, and the divide-by-two phase restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| tick_fast | input | 1 | Count enable from the fast clock source |
| tick_slow | input | 1 | Count enable from the slow clock source |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with six channels and `CNT_W` = 8. This keeps every register and mode field, but lets the free-run wrap at 256 be reached in a few hundred cycles. The bench sweeps all six channels through repeat and one-shot runs, using a different compare value and tick count per channel. It predicts each counter arithmetically (modulo the compare value, or clamped at it) and checks the pending mask as it builds up. It also drives both clock sources, both divider settings, the control-write-versus-tick collision and the acknowledge masks through the ports.

// File: rtl/ctm_pkg.sv
package ctm_pkg;

    typedef enum logic [1:0] {
        MODE_ONESHOT = 2'd0,
        MODE_REPEAT  = 2'd1,
        MODE_FREEALT = 2'd2,
        MODE_FREERUN = 2'd3
    } ctm_mode_e;

    typedef enum logic {
        CH_HALT  = 1'b0,
        CH_COUNT = 1'b1
    } ctm_state_e;

    // register offsets inside a 16-byte group (word index)
    localparam logic [1:0] OFF_CTRL = 2'd0;
    localparam logic [1:0] OFF_CLK  = 2'd1;
    localparam logic [1:0] OFF_CNT  = 2'd2;
    localparam logic [1:0] OFF_CMP  = 2'd3;

    // shared group 0 word indices
    localparam logic [1:0] OFF_IEN  = 2'd0;
    localparam logic [1:0] OFF_PEND = 2'd2;

    localparam int CTRL_RUN_BIT = 0;
    localparam int CTRL_CLR_BIT = 1;
    localparam int CTRL_MODE_LO = 4;
    localparam int CLK_DIV_BIT  = 0;
    localparam int CLK_SRC_BIT  = 4;

endpackage

// File: rtl/ctm_prescale.sv
module ctm_prescale (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic tick_fast,
    input  logic tick_slow,
    input  logic sel_slow,
    input  logic div2,
    output logic step
);
    logic phase_q;
    logic tick_sel;

    assign tick_sel = sel_slow ? tick_slow : tick_fast;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
        end else if (!run || restart) begin
            phase_q <= 1'b0;
        end else if (tick_sel && div2) begin
            phase_q <= ~phase_q;
        end
    end

    assign step = run && !restart && tick_sel && (!div2 || phase_q);
endmodule

// File: rtl/ctm_channel.sv
module ctm_channel
    import ctm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_fast,
    input  logic             tick_slow,
    input  logic             ctrl_we,
    input  logic             ctrl_run,
    input  logic             ctrl_clr,
    input  logic [1:0]       ctrl_mode,
    input  logic             clk_we,
    input  logic             clk_src,
    input  logic             clk_div,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cmp,
    output logic             running,
    output logic [1:0]       mode,
    output logic             src,
    output logic             div,
    output logic             hit
);
    ctm_state_e       state_q, state_d;
    ctm_mode_e        mode_q;
    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, cmp_q;
    logic             src_q, div_q, step, uses_cmp;

    ctm_prescale u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state_q == CH_COUNT),
        .restart  (ctrl_we),
        .tick_fast(tick_fast),
        .tick_slow(tick_slow),
        .sel_slow (src_q),
        .div2     (div_q),
        .step     (step)
    );

    assign uses_cmp = (mode_q == MODE_ONESHOT) || (mode_q == MODE_REPEAT);
    assign cnt_inc  = cnt_q + 1'b1;
    assign hit      = step && uses_cmp && (cnt_inc == cmp_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_HALT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state: start / stop / expire
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CH_HALT: begin
                if (ctrl_we && ctrl_run) state_d = CH_COUNT;
            end
            CH_COUNT: begin
                if (ctrl_we && !ctrl_run)                 state_d = CH_HALT;
                else if (hit && mode_q == MODE_ONESHOT)   state_d = CH_HALT;
                if (step) cnt_d = (hit && mode_q == MODE_REPEAT) ? '0 : cnt_inc;
            end
        endcase
        if (ctrl_we && ctrl_clr) cnt_d = '0;
    end

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_ONESHOT;
            src_q  <= 1'b0;
            div_q  <= 1'b0;
            cmp_q  <= '0;
        end else begin
            if (ctrl_we) mode_q <= ctm_mode_e'(ctrl_mode);
            if (clk_we) begin
                src_q <= clk_src;
                div_q <= clk_div;
            end
            if (cmp_we) cmp_q <= cmp_wdata;
        end
    end

    // outputs
    always_comb begin
        running = (state_q == CH_COUNT);
        cnt     = cnt_q;
        cmp     = cmp_q;
        mode    = mode_q;
        src     = src_q;
        div     = div_q;
    end
endmodule

// File: rtl/ctm_top.sv
module ctm_top
    import ctm_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_fast,
    input  logic              tick_slow,
    output logic              irq
);
    localparam int GRP_W = ADDR_W - 4;

    logic [GRP_W-1:0] grp;
    logic [1:0]       word;
    logic             aligned;

    logic [NUM_CH-1:0]            ien_q, pend_q, ch_hit, ch_run, ch_src, ch_div, ch_ctrl_we;
    logic [NUM_CH-1:0][1:0]       ch_mode;
    logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt, ch_cmp;
    logic                         ien_wr, ack_wr;

    assign grp     = bus_addr[ADDR_W-1:4];
    assign word    = bus_addr[3:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign ien_wr  = bus_we && aligned && grp == '0 && word == OFF_IEN;
    assign ack_wr  = bus_we && aligned && grp == '0 && word == OFF_PEND;

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        logic sel;
        assign sel           = bus_we && aligned && (grp == GRP_W'(k + 1));
        assign ch_ctrl_we[k] = sel && word == OFF_CTRL;

        ctm_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_fast (tick_fast),
            .tick_slow (tick_slow),
            .ctrl_we   (ch_ctrl_we[k]),
            .ctrl_run  (bus_wdata[CTRL_RUN_BIT]),
            .ctrl_clr  (bus_wdata[CTRL_CLR_BIT]),
            .ctrl_mode (bus_wdata[CTRL_MODE_LO+1:CTRL_MODE_LO]),
            .clk_we    (sel && word == OFF_CLK),
            .clk_src   (bus_wdata[CLK_SRC_BIT]),
            .clk_div   (bus_wdata[CLK_DIV_BIT]),
            .cmp_we    (sel && word == OFF_CMP),
            .cmp_wdata (bus_wdata[CNT_W-1:0]),
            .cnt       (ch_cnt[k]),
            .cmp       (ch_cmp[k]),
            .running   (ch_run[k]),
            .mode      (ch_mode[k]),
            .src       (ch_src[k]),
            .div       (ch_div[k]),
            .hit       (ch_hit[k])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q  <= '0;
            pend_q <= '0;
        end else begin
            if (ien_wr) ien_q <= bus_wdata[NUM_CH-1:0];
            pend_q <= (pend_q & ~(ack_wr ? bus_wdata[NUM_CH-1:0] : '0)) | ch_hit;
        end
    end

    assign irq = |(pend_q & ien_q);

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            if (grp == '0) begin
                if (word == OFF_IEN)  bus_rdata[NUM_CH-1:0] = ien_q;
                if (word == OFF_PEND) bus_rdata[NUM_CH-1:0] = pend_q;
            end
            for (int k = 0; k < NUM_CH; k++) begin
                if (grp == GRP_W'(k + 1)) begin
                    unique case (word)
                        OFF_CTRL: begin
                            bus_rdata[CTRL_RUN_BIT]                     = ch_run[k];
                            bus_rdata[CTRL_MODE_LO+1:CTRL_MODE_LO]      = ch_mode[k];
                        end
                        OFF_CLK: begin
                            bus_rdata[CLK_SRC_BIT] = ch_src[k];
                            bus_rdata[CLK_DIV_BIT] = ch_div[k];
                        end
                        OFF_CNT: bus_rdata[CNT_W-1:0] = ch_cnt[k];
                        OFF_CMP: bus_rdata[CNT_W-1:0] = ch_cmp[k];
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/ctm_checker.sv
module ctm_checker #(
    parameter int NUM_CH = 6,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         bus_we,
    input logic [ADDR_W-1:0]            bus_addr,
    input logic [NUM_CH-1:0]            ack_bits,
    input logic                         clr_bit,
    input logic [NUM_CH-1:0]            pend_q,
    input logic [NUM_CH-1:0]            ch_hit,
    input logic [NUM_CH-1:0]            ch_run,
    input logic [NUM_CH-1:0]            ch_ctrl_we,
    input logic [NUM_CH-1:0][1:0]       ch_mode,
    input logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt
);
    logic ack_access;
    assign ack_access = bus_we && bus_addr == ADDR_W'(8);

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_access |=> ((pend_q & $past(ack_bits & ~ch_hit)) == '0));

    for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
        assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_ctrl_we[k] && clr_bit) |=> (ch_cnt[k] == '0));

        assert_halt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_run[k] && !ch_ctrl_we[k]) |=> $stable(ch_cnt[k]));

        assert_repeat_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_hit[k] && ch_mode[k] == 2'd1) |=> (ch_cnt[k] == '0 && ch_run[k]));

        assert_oneshot_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_hit[k] && ch_mode[k] == 2'd0) |=> !ch_run[k]);

        assert_freerun_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_q[k]) |-> !$past(ch_mode[k][1]));
    end
endmodule

bind ctm_top ctm_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .ack_bits   (bus_wdata[NUM_CH-1:0]),
    .clr_bit    (bus_wdata[1]),
    .pend_q     (pend_q),
    .ch_hit     (ch_hit),
    .ch_run     (ch_run),
    .ch_ctrl_we (ch_ctrl_we),
    .ch_mode    (ch_mode),
    .ch_cnt     (ch_cnt)
);

// File: tb/ctm_top_tb_top.sv
module ctm_top_tb_top;
    localparam int NUM_CH = 6;
    localparam int CNT_W  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_fast = 1'b0;
    logic        tick_slow = 1'b0;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ctm_top #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(8), .DATA_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_fast(tick_fast), .tick_slow(tick_slow), .irq(irq)
    );

    // all tasks are entered at or just after a falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ticks(input logic f, input logic s, input int n);
        tick_fast = f; tick_slow = s;
        repeat (n) @(negedge clk);
        tick_fast = 1'b0; tick_slow = 1'b0;
    endtask

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic chk_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [5:0]  pmask;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R2 unmapped addresses
        chk_reg("R1 ien", 8'h00, 0);
        chk_reg("R1 pend", 8'h08, 0);
        check("R1 irq", {31'b0, irq}, 0);
        for (int n = 1; n <= NUM_CH; n++) begin
            for (int w = 0; w < 4; w++) chk_reg("R1 channel reg", 8'(n * 16 + w * 4), 0);
        end
        chk_reg("R2 unmapped 0x04", 8'h04, 0);
        chk_reg("R2 unmapped 0x0C", 8'h0C, 0);

        // R5 repeat sweep, pending accumulates; R4 halt hold; R3 clear
        pmask = '0;
        for (int n = 1; n <= NUM_CH; n++) begin
            int c, s;
            c = n + 2;
            s = 2 * c + n;
            wr(8'(n * 16 + 12), c);
            chk_reg("R2 compare readback", 8'(n * 16 + 12), c);
            wr(8'(n * 16), 32'h11);
            chk_reg("R3 running repeat", 8'(n * 16), 32'h11);
            ticks(1'b1, 1'b0, s);
            chk_reg("R5 repeat count", 8'(n * 16 + 8), s % c);
            pmask[n-1] = 1'b1;
            chk_reg("R5 pending", 8'h08, {26'b0, pmask});
            wr(8'(n * 16), 32'h10);
            ticks(1'b1, 1'b0, 4);
            chk_reg("R4 halted hold", 8'(n * 16 + 8), s % c);
            wr(8'(n * 16 + 8), 32'hAA);
            chk_reg("R2 counter write ignored", 8'(n * 16 + 8), s % c);
            wr(8'(n * 16), 32'h12);
            chk_reg("R3 clear", 8'(n * 16 + 8), 0);
            chk_reg("R3 clear bit reads 0", 8'(n * 16), 32'h10);
        end
        check("R9 no irq without enable", {31'b0, irq}, 0);

        // R9 / R8 interrupt combine and acknowledge
        wr(8'h00, 32'h04);
        chk_reg("R2 ien readback", 8'h00, 32'h04);
        check("R9 irq on enabled pending", {31'b0, irq}, 1);
        wr(8'h08, 32'h04);
        chk_reg("R8 single ack", 8'h08, 32'h3B);
        check("R9 irq after ack", {31'b0, irq}, 0);
        wr(8'h00, 32'h21);
        check("R9 irq other channel", {31'b0, irq}, 1);
        wr(8'h08, 32'h3F);
        chk_reg("R8 ack all", 8'h08, 0);
        check("R9 irq cleared", {31'b0, irq}, 0);
        wr(8'h00, 32'h00);

        // R6 one-shot: not yet expired
        wr(8'h1C, 10);
        wr(8'h10, 32'h03);
        ticks(1'b1, 1'b0, 4);
        chk_reg("R6 before match count", 8'h18, 4);
        chk_reg("R6 before match running", 8'h10, 32'h01);
        chk_reg("R6 before match pend", 8'h08, 0);
        // R6 one-shot sweep
        pmask = '0;
        for (int n = 1; n <= NUM_CH; n++) begin
            int c;
            c = n + 3;
            wr(8'(n * 16 + 12), c);
            wr(8'(n * 16), 32'h03);
            ticks(1'b1, 1'b0, c + 2);
            chk_reg("R6 holds at compare", 8'(n * 16 + 8), c);
            chk_reg("R6 enable cleared", 8'(n * 16), 0);
            pmask[n-1] = 1'b1;
            chk_reg("R6 pending", 8'h08, {26'b0, pmask});
        end
        wr(8'h08, 32'h3F);

        // R4 clock source and divider on channel 2 (free-run)
        wr(8'h24, 32'h01);
        chk_reg("R4 clock readback div", 8'h24, 32'h01);
        wr(8'h20, 32'h33);
        ticks(1'b1, 1'b0, 7);
        chk_reg("R4 divide by two", 8'h28, 3);
        wr(8'h24, 32'h10);
        wr(8'h20, 32'h33);
        ticks(1'b1, 1'b0, 5);
        chk_reg("R4 fast ignored on slow", 8'h28, 0);
        ticks(1'b0, 1'b1, 5);
        chk_reg("R4 slow ticks", 8'h28, 5);
        wr(8'h24, 32'h11);
        chk_reg("R4 clock readback both", 8'h24, 32'h11);
        ticks(1'b0, 1'b1, 9);
        chk_reg("R4 slow divided", 8'h28, 9);

        // R7 free-run wrap, mode 3 and mode 2
        wr(8'h3C, 5);
        wr(8'h30, 32'h33);
        ticks(1'b1, 1'b0, 300);
        chk_reg("R7 mode3 wrap", 8'h38, 300 % 256);
        wr(8'h4C, 5);
        wr(8'h40, 32'h23);
        ticks(1'b1, 1'b0, 260);
        chk_reg("R7 mode2 wrap", 8'h48, 260 % 256);
        chk_reg("R7 no pending", 8'h08, 0);
        chk_reg("R3 mode2 readback", 8'h40, 32'h21);

        // R10 control write during ticking
        wr(8'h50, 32'h33);
        tick_fast = 1'b1;
        repeat (3) @(negedge clk);
        wr(8'h50, 32'h31);
        repeat (2) @(negedge clk);
        tick_fast = 1'b0;
        chk_reg("R10 write cycle skips step", 8'h58, 5);
        // R10 divider phase restart: one tick, rewrite, one tick -> no advance
        wr(8'h54, 32'h01);
        wr(8'h50, 32'h33);
        ticks(1'b1, 1'b0, 1);
        wr(8'h50, 32'h31);
        ticks(1'b1, 1'b0, 1);
        chk_reg("R10 phase restart", 8'h58, 0);
        ticks(1'b1, 1'b0, 1);
        chk_reg("R10 second tick advances", 8'h58, 1);

        rd(8'h08, v);
        check("R7 no pending after all free-run", v, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule